// File: doc/BRIEF.md
# NAND Flash Bus Cycle Timing Sequencer

This block sits on the host side of an asynchronous NAND flash interface and turns single bus-cycle requests into correctly timed strobe waveforms. Commands, addresses and data all travel over one shared I/O bus of 8 or 16 bits. A client hands over one request at a time through a valid/ready handshake. Each request is a command latch, an address latch, a data write or a data read. The block then drives chip enable, the command and address latch enables, the write and read strobes and the I/O output enable. It reports completion with a one-cycle done pulse that carries the read data.

Every strobe minimum is set in nanoseconds and converted to clock cycles, rounding up. The write and read strobes each have a low-time, a high-time and a whole-cycle limit. The latch enables and chip enable lead each strobe by a setup phase. Read data is captured on the edge that ends the read-strobe low phase.

The block watches the open-drain ready/busy line through a two-flop synchronizer and starts nothing while the memory reports busy. After each command cycle it waits for a guard window, because the memory needs that time to pull the line low. A write-protect input makes the block refuse command cycles whose opcode belongs to a configurable set of program and erase opcodes. A refused request completes at once with a blocked flag and produces no strobe. On the 16-bit bus, command and address cycles drive zero on the upper byte.

Top module: `nand_strobe_seq`

## Requirements
- R1: Request kind encodings are 0 = command, 1 = address, 2 = data write, 3 = data read. For kinds 0, 1 and 2, chip enable is low, `io_oe` is high and `io_out` equals the request data at the moment `we_n` falls. `cle` is high only for kind 0 and `ale` only for kind 1. Chip enable is low for exactly ceil(SETUP_NS/clock) cycles before the fall.
- R2: `we_n` stays low for exactly ceil(WL_NS/clock) cycles per write-type cycle.
- R3: Between two write-strobe pulses, `we_n` stays high for at least max(ceil(WH_NS), ceil(WC_NS) - ceil(WL_NS)) cycles. Fall-to-fall spacing is at least ceil(WC_NS) cycles.
- R4: `re_n` stays low for exactly ceil(RL_NS) cycles. Between read pulses it stays high for at least max(ceil(RH_NS), ceil(RC_NS) - ceil(RL_NS)) cycles, with fall-to-fall spacing of at least ceil(RC_NS).
- R5: During a read cycle `io_oe` is low. `done_rdata` equals the value on `io_in` in the last cycle of the `re_n` low phase.
- R6: While `rb_n` is low (seen through a two-cycle synchronizer), `req_ready` is low and no strobe cycle starts.
- R7: With `wp_on` high, a kind-0 request whose low data byte is 0x80, 0x60, 0x10 or 0xD0 produces no strobe. Its `done_valid` comes one cycle after acceptance, with `done_blocked` high. Other opcodes and other kinds are unaffected.
- R8: After a command cycle completes, `req_ready` stays low for exactly ceil(BUSY_GUARD_NS) cycles. No guard follows the other kinds.
- R9: Each accepted strobe request gives one `done_valid` pulse. It appears setup + low + high cycles after the accepting edge, with `done_blocked` low.
- R10: In reset, `ce_n`, `we_n` and `re_n` are high, `cle`, `ale`, `io_oe` and `done_valid` are low, and `req_ready` is high once reset is released with `rb_n` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Request can be taken this cycle |
| req_kind | input | 2 | 0 command, 1 address, 2 write, 3 read |
| req_wdata | input | IO_W | Opcode, address byte or write data |
| wp_on | input | 1 | Refuse program and erase opcodes |
| done_valid | output | 1 | One-cycle completion pulse |
| done_rdata | output | IO_W | Data captured by the last read |
| done_blocked | output | 1 | Completed request was refused |
| ce_n | output | 1 | Chip enable, active low |
| cle | output | 1 | Command latch enable |
| ale | output | 1 | Address latch enable |
| we_n | output | 1 | Write strobe, active low |
| re_n | output | 1 | Read strobe, active low |
| io_out | output | IO_W | Bus value driven by the host |
| io_oe | output | 1 | Host drives the bus |
| io_in | input | IO_W | Bus value driven by the memory |
| rb_n | input | 1 | Open-drain ready/busy, low = busy |

## Verification
Two functions can collide: the memory pulling ready/busy low and a request being accepted, both in the same cycle. The bench provokes this by asserting `req_valid` and pulling `rb_n` low on the same sampling point. The judgement is that the request already in flight finishes with its normal latency. `req_ready` must then stay low until `rb_n` returns high, and no further strobe may appear in that window. The other sweeps cover all 256 command opcodes with protection both on and off, plus runs of back-to-back writes, address latches and reads. In those sweeps, pulse widths and spacings are measured against the nanosecond-to-cycle arithmetic.

// File: rtl/nss_pkg.sv
package nss_pkg;

   typedef enum logic [1:0] {
      K_CMD   = 2'd0,
      K_ADDR  = 2'd1,
      K_WRITE = 2'd2,
      K_READ  = 2'd3
   } kind_e;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_SETUP,
      ST_WLOW,
      ST_WHIGH,
      ST_RLOW,
      ST_RHIGH
   } st_e;

   // nanoseconds to whole clock cycles, rounded up
   function automatic int ns2cyc(input int ns, input int clk_ps);
      return (ns * 1000 + clk_ps - 1) / clk_ps;
   endfunction

   function automatic int imax(input int a, input int b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/nss_phase_timer.sv
module nss_phase_timer #(
   parameter int CW = 4
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load,
   input  logic [CW-1:0] load_val,
   output logic          zero
);
   logic [CW-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)             cnt <= '0;
      else if (load)          cnt <= load_val;
      else if (cnt != '0)     cnt <= cnt - 1'b1;
   end

   assign zero = (cnt == '0);
endmodule

// File: rtl/nss_rb_sync.sv
module nss_rb_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic rb_n,
   output logic rb_ok
);
   logic [STAGES-1:0] sh;

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("nss_rb_sync needs at least two stages");
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sh <= '1;
      else        sh <= {sh[STAGES-2:0], rb_n};
   end

   assign rb_ok = sh[STAGES-1];
endmodule

// File: rtl/nss_wp_gate.sv
module nss_wp_gate #(
   parameter int                WP_N   = 4,
   parameter logic [WP_N*8-1:0] WP_OPS = {8'h80, 8'h60, 8'h10, 8'hD0}
) (
   input  logic       wp_on,
   input  logic       is_cmd,
   input  logic [7:0] opcode,
   output logic       blocked
);
   logic [WP_N-1:0] hit;

   generate
      if (WP_N < 1) begin : g_bad_n
         $error("nss_wp_gate needs at least one opcode");
      end
      for (genvar i = 0; i < WP_N; i++) begin : g_cmp
         assign hit[i] = (opcode == WP_OPS[i*8 +: 8]);
      end
   endgenerate

   assign blocked = wp_on && is_cmd && (|hit);
endmodule

// File: rtl/nand_strobe_seq.sv
module nand_strobe_seq
   import nss_pkg::*;
#(
   parameter int                IO_W          = 8,
   parameter int                CLK_PS        = 4000,
   parameter int                SETUP_NS      = 10,
   parameter int                WL_NS         = 40,
   parameter int                WH_NS         = 20,
   parameter int                WC_NS         = 60,
   parameter int                RL_NS         = 40,
   parameter int                RH_NS         = 20,
   parameter int                RC_NS         = 60,
   parameter int                RACC_NS       = 35,
   parameter int                BUSY_GUARD_NS = 100,
   parameter int                WP_N          = 4,
   parameter logic [WP_N*8-1:0] WP_OPS        = {8'h80, 8'h60, 8'h10, 8'hD0}
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            req_valid,
   output logic            req_ready,
   input  logic [1:0]      req_kind,
   input  logic [IO_W-1:0] req_wdata,
   input  logic            wp_on,
   output logic            done_valid,
   output logic [IO_W-1:0] done_rdata,
   output logic            done_blocked,
   output logic            ce_n,
   output logic            cle,
   output logic            ale,
   output logic            we_n,
   output logic            re_n,
   output logic [IO_W-1:0] io_out,
   output logic            io_oe,
   input  logic [IO_W-1:0] io_in,
   input  logic            rb_n
);
   // derived cycle counts
   localparam int SU_CYC    = ns2cyc(SETUP_NS, CLK_PS);
   localparam int WL_CYC    = ns2cyc(WL_NS, CLK_PS);
   localparam int WHI_CYC   = imax(ns2cyc(WH_NS, CLK_PS), ns2cyc(WC_NS, CLK_PS) - WL_CYC);
   localparam int RL_CYC    = ns2cyc(RL_NS, CLK_PS);
   localparam int RHI_CYC   = imax(ns2cyc(RH_NS, CLK_PS), ns2cyc(RC_NS, CLK_PS) - RL_CYC);
   localparam int RACC_CYC  = ns2cyc(RACC_NS, CLK_PS);
   localparam int GUARD_CYC = ns2cyc(BUSY_GUARD_NS, CLK_PS);
   localparam int TMAX      = imax(imax(SU_CYC, WL_CYC), imax(imax(WHI_CYC, RL_CYC), RHI_CYC));
   localparam int CW        = $clog2(TMAX + 1);
   localparam int GW        = $clog2(GUARD_CYC + 2);

   generate
      if (IO_W != 8 && IO_W != 16) begin : g_bad_width
         $error("IO_W must be 8 or 16");
      end
      if (SU_CYC < 1 || WL_CYC < 1 || WHI_CYC < 1 || RL_CYC < 1 || RHI_CYC < 1) begin : g_bad_phase
         $error("every strobe phase must last at least one cycle");
      end
      if (RACC_CYC > RL_CYC) begin : g_bad_access
         $error("access delay exceeds read strobe low time");
      end
   endgenerate

   st_e             st;
   kind_e           kind_q;
   logic [IO_W-1:0] data_q;
   logic [IO_W-1:0] rdata_q;
   logic            accept, blk, rb_ok;
   logic            t_load, t_zero;
   logic [CW-1:0]   t_val;
   logic            g_load, g_zero;

   // ready/busy synchronizer
   nss_rb_sync #(.STAGES(2)) u_rb (
      .clk(clk), .rst_n(rst_n), .rb_n(rb_n), .rb_ok(rb_ok)
   );

   // write-protect opcode gate
   nss_wp_gate #(.WP_N(WP_N), .WP_OPS(WP_OPS)) u_wp (
      .wp_on(wp_on),
      .is_cmd(req_kind == K_CMD),
      .opcode(req_wdata[7:0]),
      .blocked(blk)
   );

   // phase timer
   nss_phase_timer #(.CW(CW)) u_phase (
      .clk(clk), .rst_n(rst_n), .load(t_load), .load_val(t_val), .zero(t_zero)
   );

   // post-command busy guard timer
   nss_phase_timer #(.CW(GW)) u_guard (
      .clk(clk), .rst_n(rst_n), .load(g_load), .load_val(GW'(GUARD_CYC)), .zero(g_zero)
   );

   assign req_ready = (st == ST_IDLE) && rb_ok && g_zero;
   assign accept    = req_valid && req_ready;
   assign g_load    = (st == ST_WHIGH) && t_zero && (kind_q == K_CMD);

   always_comb begin
      t_load = 1'b0;
      t_val  = '0;
      case (st)
         ST_IDLE: if (accept && !blk) begin
            t_load = 1'b1;
            t_val  = CW'(SU_CYC - 1);
         end
         ST_SETUP: if (t_zero) begin
            t_load = 1'b1;
            t_val  = (kind_q == K_READ) ? CW'(RL_CYC - 1) : CW'(WL_CYC - 1);
         end
         ST_WLOW: if (t_zero) begin
            t_load = 1'b1;
            t_val  = CW'(WHI_CYC - 1);
         end
         ST_RLOW: if (t_zero) begin
            t_load = 1'b1;
            t_val  = CW'(RHI_CYC - 1);
         end
         default: ;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st           <= ST_IDLE;
         kind_q       <= K_CMD;
         data_q       <= '0;
         rdata_q      <= '0;
         done_valid   <= 1'b0;
         done_blocked <= 1'b0;
      end else begin
         done_valid <= 1'b0;
         case (st)
            ST_IDLE: if (accept) begin
               kind_q <= kind_e'(req_kind);
               data_q <= req_wdata;
               if (blk) begin
                  done_valid   <= 1'b1;
                  done_blocked <= 1'b1;
               end else begin
                  done_blocked <= 1'b0;
                  st           <= ST_SETUP;
               end
            end
            ST_SETUP: if (t_zero) st <= (kind_q == K_READ) ? ST_RLOW : ST_WLOW;
            ST_WLOW:  if (t_zero) st <= ST_WHIGH;
            ST_RLOW:  if (t_zero) begin
               st      <= ST_RHIGH;
               rdata_q <= io_in;
            end
            ST_WHIGH, ST_RHIGH: if (t_zero) begin
               st         <= ST_IDLE;
               done_valid <= 1'b1;
            end
            default: st <= ST_IDLE;
         endcase
      end
   end

   // bus pin decode
   logic wr_phase;
   assign wr_phase   = (st == ST_WLOW) || (st == ST_WHIGH) ||
                       ((st == ST_SETUP) && (kind_q != K_READ));
   assign ce_n       = (st == ST_IDLE);
   assign we_n       = (st != ST_WLOW);
   assign re_n       = (st != ST_RLOW);
   assign cle        = wr_phase && (kind_q == K_CMD);
   assign ale        = wr_phase && (kind_q == K_ADDR);
   assign io_oe      = wr_phase;
   assign done_rdata = rdata_q;

   generate
      if (IO_W == 16) begin : g_wide
         assign io_out = (kind_q == K_WRITE) ? data_q : {8'h00, data_q[7:0]};
      end else begin : g_narrow
         assign io_out = data_q;
      end
   endgenerate

   // ---- strobe run-length monitors for assertions ----
   logic [15:0] we_lo_run, we_hi_run, re_lo_run, re_hi_run;
   logic        we_n_d, re_n_d;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         we_lo_run <= '0; we_hi_run <= '1; re_lo_run <= '0; re_hi_run <= '1;
         we_n_d    <= 1'b1; re_n_d <= 1'b1;
      end else begin
         we_n_d    <= we_n;
         re_n_d    <= re_n;
         we_lo_run <= we_n ? '0 : we_lo_run + 1'b1;
         re_lo_run <= re_n ? '0 : re_lo_run + 1'b1;
         we_hi_run <= !we_n ? '0 : ((we_hi_run == '1) ? we_hi_run : we_hi_run + 1'b1);
         re_hi_run <= !re_n ? '0 : ((re_hi_run == '1) ? re_hi_run : re_hi_run + 1'b1);
      end
   end

   // R2: write strobe low time
   a_r2_we_low_min: assert property (@(posedge clk) disable iff (!rst_n)
      (we_n && !we_n_d) |-> (we_lo_run >= 16'(WL_CYC)));

   // R3: write strobe high time
   a_r3_we_high_min: assert property (@(posedge clk) disable iff (!rst_n)
      (!we_n && we_n_d) |-> (we_hi_run >= 16'(WHI_CYC)));

   // R4: read strobe low and high times
   a_r4_re_low_min: assert property (@(posedge clk) disable iff (!rst_n)
      (re_n && !re_n_d) |-> (re_lo_run >= 16'(RL_CYC)));
   a_r4_re_high_min: assert property (@(posedge clk) disable iff (!rst_n)
      (!re_n && re_n_d) |-> (re_hi_run >= 16'(RHI_CYC)));

   // R5: host never drives during a read strobe
   a_r5_no_drive_on_read: assert property (@(posedge clk) disable iff (!rst_n)
      !re_n |-> !io_oe);

   // R1: latch enables exclusive, bus driven and chip selected under write strobe
   a_r1_latch_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
      !(cle && ale) && !(!we_n && !re_n));
   a_r1_we_context: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(we_n) |-> (io_oe && !ce_n));

   // R6: a cycle only opens when the synchronized line reported ready
   a_r6_start_when_ready: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(ce_n) |-> $past(rb_ok));

   // R7: refused request completes next cycle without any strobe
   a_r7_blocked_done: assert property (@(posedge clk) disable iff (!rst_n)
      (accept && blk) |=> (done_valid && done_blocked && ce_n && we_n));

endmodule

// File: tb/nand_strobe_seq_tb.sv
module nand_strobe_seq_tb_top;

   localparam int CLK_PS = 4000;
   // small configuration overrides
   localparam int WC_NS   = 80;
   localparam int RL_NS   = 30;
   localparam int RACC_NS = 25;

   // expected cycle counts computed here from the nanosecond limits
   localparam int SU_E    = (10 * 1000 + CLK_PS - 1) / CLK_PS;
   localparam int WL_E    = (40 * 1000 + CLK_PS - 1) / CLK_PS;
   localparam int WH_E    = (20 * 1000 + CLK_PS - 1) / CLK_PS;
   localparam int WC_E    = (WC_NS * 1000 + CLK_PS - 1) / CLK_PS;
   localparam int WHI_E   = (WH_E > WC_E - WL_E) ? WH_E : WC_E - WL_E;
   localparam int RL_E    = (RL_NS * 1000 + CLK_PS - 1) / CLK_PS;
   localparam int RH_E    = (20 * 1000 + CLK_PS - 1) / CLK_PS;
   localparam int RC_E    = (60 * 1000 + CLK_PS - 1) / CLK_PS;
   localparam int RHI_E   = (RH_E > RC_E - RL_E) ? RH_E : RC_E - RL_E;
   localparam int RACC_E  = (RACC_NS * 1000 + CLK_PS - 1) / CLK_PS;
   localparam int GUARD_E = (100 * 1000 + CLK_PS - 1) / CLK_PS;
   localparam int WLAT_E  = SU_E + WL_E + WHI_E + 1;
   localparam int RLAT_E  = SU_E + RL_E + RHI_E + 1;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic req_valid = 1'b0;
   logic req_ready;
   logic [1:0] req_kind = 2'd0;
   logic [7:0] req_wdata = 8'd0;
   logic wp_on = 1'b0;
   logic done_valid, done_blocked;
   logic [7:0] done_rdata;
   logic ce_n, cle, ale, we_n, re_n, io_oe;
   logic [7:0] io_out;
   logic [7:0] io_in = 8'd0;
   logic rb_n = 1'b1;

   int vectors = 0;
   int fails = 0;

   always #2ns clk = ~clk;

   nand_strobe_seq #(
      .IO_W(8), .CLK_PS(CLK_PS), .WC_NS(WC_NS), .RL_NS(RL_NS), .RACC_NS(RACC_NS)
   ) dut_i (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
      .req_kind(req_kind), .req_wdata(req_wdata), .wp_on(wp_on),
      .done_valid(done_valid), .done_rdata(done_rdata), .done_blocked(done_blocked),
      .ce_n(ce_n), .cle(cle), .ale(ale), .we_n(we_n), .re_n(re_n),
      .io_out(io_out), .io_oe(io_oe), .io_in(io_in), .rb_n(rb_n)
   );

   // ---- waveform monitor, sampled on the falling clock edge ----
   bit   prev_we = 1, prev_re = 1;
   int   we_lo = 0, we_hi = 1000, we_gap = 1000, we_falls = 0;
   int   last_we_lo = 0, last_we_hi = 1000, last_we_gap = 1000;
   int   re_lo = 0, re_hi = 1000, re_gap = 1000, re_falls = 0;
   int   last_re_lo = 0, last_re_hi = 1000, last_re_gap = 1000;
   int   ce_lo = 0, cap_ce_setup = 0;
   bit   cap_cle, cap_ale, cap_oe, cap_re_oe;
   logic [7:0] cap_io;
   logic [7:0] rd_pat = 8'd0;

   always @(negedge clk) begin
      if (!ce_n) ce_lo++; else ce_lo = 0;
      if (!we_n) begin
         if (prev_we) begin
            last_we_hi = we_hi; last_we_gap = we_gap; we_gap = 0; we_lo = 0;
            cap_cle = cle; cap_ale = ale; cap_oe = io_oe; cap_io = io_out;
            cap_ce_setup = ce_lo - 1;
            we_falls++;
         end
         we_lo++;
      end else begin
         if (!prev_we) begin last_we_lo = we_lo; we_hi = 0; end
         we_hi++;
      end
      we_gap++;
      prev_we = we_n;
      if (!re_n) begin
         if (prev_re) begin
            last_re_hi = re_hi; last_re_gap = re_gap; re_gap = 0; re_lo = 0;
            cap_re_oe = io_oe; re_falls++;
         end
         re_lo++;
      end else begin
         if (!prev_re) begin last_re_lo = re_lo; re_hi = 0; end
         re_hi++;
      end
      re_gap++;
      prev_re = re_n;
      // memory model: valid data only once the access delay has elapsed
      io_in = (!re_n && re_lo >= RACC_E) ? rd_pat : ~rd_pat;
   end

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      vectors++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic report();
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
   endtask

   // issue one request at a falling edge, return negedge count until done
   task automatic do_req(input int kind, input int data, output int lat);
      while (!req_ready) @(negedge clk);
      req_kind  = 2'(kind);
      req_wdata = 8'(data);
      req_valid = 1'b1;
      @(negedge clk);
      req_valid = 1'b0;
      lat = 1;
      while (!done_valid) begin
         @(negedge clk);
         lat++;
      end
   endtask

   task automatic write_like(input int kind, input int data, input bit first);
      int lat, f0;
      f0 = we_falls;
      do_req(kind, data, lat);
      chk(we_falls == f0 + 1, "R9 one strobe", we_falls - f0, 1);
      chk(lat == WLAT_E && !done_blocked, "R9 latency", lat, WLAT_E);
      chk(last_we_lo == WL_E, "R2 we low", last_we_lo, WL_E);
      chk(cap_io == 8'(data) && cap_oe, "R1 bus value", cap_io, data);
      chk(cap_cle == (kind == 0) && cap_ale == (kind == 1), "R1 latch enables",
          {cap_cle, cap_ale}, {kind == 0, kind == 1});
      chk(cap_ce_setup == SU_E, "R1 setup", cap_ce_setup, SU_E);
      if (!first) begin
         chk(last_we_hi >= WHI_E, "R3 we high", last_we_hi, WHI_E);
         chk(last_we_gap >= WC_E, "R3 we cycle", last_we_gap, WC_E);
      end
   endtask

   function automatic bit is_pe(input int op);
      return op == 8'h80 || op == 8'h60 || op == 8'h10 || op == 8'hD0;
   endfunction

   initial begin
      repeat (3) @(negedge clk);
      // R10 reset state
      chk(ce_n && we_n && re_n, "R10 strobes idle in reset", {ce_n, we_n, re_n}, 7);
      chk(!cle && !ale && !io_oe && !done_valid, "R10 enables low in reset",
          {cle, ale, io_oe, done_valid}, 0);
      rst_n = 1'b1;
      repeat (3) @(negedge clk);
      chk(req_ready, "R10 ready after reset", req_ready, 1);

      // data writes, back to back
      for (int i = 0; i < 32; i++) write_like(2, i * 7 + 3, i == 0);
      // address latches
      for (int i = 0; i < 32; i++) write_like(1, 255 - i * 5, 1'b0);

      // reads
      for (int i = 0; i < 32; i++) begin
         int lat, f0;
         rd_pat = 8'(i * 11 + 5);
         f0 = re_falls;
         do_req(3, 0, lat);
         chk(done_rdata == rd_pat, "R5 read data", done_rdata, rd_pat);
         chk(!cap_re_oe, "R5 bus released", cap_re_oe, 0);
         chk(last_re_lo == RL_E, "R4 re low", last_re_lo, RL_E);
         chk(lat == RLAT_E && re_falls == f0 + 1, "R9 read latency", lat, RLAT_E);
         if (i > 0) begin
            chk(last_re_hi >= RHI_E, "R4 re high", last_re_hi, RHI_E);
            chk(last_re_gap >= RC_E, "R4 re cycle", last_re_gap, RC_E);
         end
      end

      // every command opcode, protection off and on
      for (int w = 0; w < 2; w++) begin
         for (int op = 0; op < 256; op++) begin
            int lat, f0, g;
            wp_on = (w == 1);
            f0 = we_falls;
            do_req(0, op, lat);
            if (w == 1 && is_pe(op)) begin
               chk(we_falls == f0 && lat == 1 && done_blocked, "R7 refused opcode",
                   we_falls - f0, 0);
            end else begin
               chk(we_falls == f0 + 1 && !done_blocked && cap_cle && cap_io == 8'(op),
                   "R7 opcode passes", we_falls - f0, 1);
               chk(lat == WLAT_E, "R9 command latency", lat, WLAT_E);
               g = 0;
               while (!req_ready) begin @(negedge clk); g++; end
               chk(g == GUARD_E, "R8 busy guard", g, GUARD_E);
            end
         end
      end

      // protection leaves other kinds alone, address 0x80 still latched
      begin
         int lat, f0;
         wp_on = 1'b1;
         f0 = we_falls;
         do_req(1, 8'h80, lat);
         chk(we_falls == f0 + 1 && !done_blocked && cap_ale, "R7 address unaffected",
             we_falls - f0, 1);
         chk(req_ready, "R8 no guard after address", req_ready, 1);
         wp_on = 1'b0;
      end

      // R6 busy holds off requests
      begin
         int lat, f0;
         @(negedge clk);
         rb_n = 1'b0;
         repeat (3) @(negedge clk);
         chk(!req_ready, "R6 ready low while busy", req_ready, 0);
         f0 = we_falls;
         req_kind = 2'd2; req_wdata = 8'h5A; req_valid = 1'b1;
         repeat (30) @(negedge clk);
         chk(we_falls == f0 && ce_n, "R6 no strobe while busy", we_falls - f0, 0);
         rb_n = 1'b1;
         lat = 0;
         while (!req_ready) begin @(negedge clk); lat++; end
         @(negedge clk);
         req_valid = 1'b0;
         while (!done_valid) @(negedge clk);
         chk(we_falls == f0 + 1 && cap_io == 8'h5A, "R6 resumes after ready", we_falls - f0, 1);
      end

      // request accepted in the same cycle ready/busy falls
      begin
         int lat, f0;
         while (!req_ready) @(negedge clk);
         f0 = we_falls;
         req_kind = 2'd1; req_wdata = 8'h3C; req_valid = 1'b1; rb_n = 1'b0;
         @(negedge clk);
         req_valid = 1'b0;
         lat = 1;
         while (!done_valid) begin @(negedge clk); lat++; end
         chk(lat == WLAT_E && cap_io == 8'h3C, "R9 in-flight cycle completes", lat, WLAT_E);
         req_kind = 2'd2; req_wdata = 8'h77; req_valid = 1'b1;
         repeat (20) @(negedge clk);
         chk(!req_ready && we_falls == f0 + 1, "R6 held after busy edge", we_falls - f0, 1);
         rb_n = 1'b1;
         while (!req_ready) @(negedge clk);
         @(negedge clk);
         req_valid = 1'b0;
         while (!done_valid) @(negedge clk);
         chk(cap_io == 8'h77 && we_falls == f0 + 2, "R6 next cycle after release", cap_io, 8'h77);
      end

      report();
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      fails++;
      $display("FAIL watchdog expired");
      report();
      $finish;
   end

endmodule